// File: doc/BRIEF.md
# Phase-Sampled External Event Counter

This block counts rising edges on an asynchronous external input pin with an 8-bit up-counter. The core clock is the oscillator clock. Every group of four oscillator periods forms one instruction cycle, split into phases Q1 through Q4. The input is looked at only at the end of Q2 and at the end of Q4. Any rising edge seen there is applied to the counter at the end of the next Q4. This fixed sampling grid gives a bounded delay from an input edge to the count change, and a clear rule for how short a pulse may be before it is lost.

An optional power-of-two prescaler can be placed in front of the sampler, so the counter advances once for every 2 to 256 input edges. Software can load the counter with a new value. Software also reads a sticky wrap flag, which is set when the counter passes from 0xFF to 0x00.

Top module: `ext_event_timer`

## Requirements
- R1: The phase advances Q1, Q2, Q3, Q4 and then back to Q1, one phase per clock, starting with Q1 in the first cycle after reset. The count source is captured only at the clock edges that end Q2 and Q4.
- R2: `count_o` changes only at a clock edge that ends Q4, except when it is loaded through `wr_en_i`.
- R3: A rising edge is detected when a capture is 1 and the previous capture was 0. Each detected edge adds exactly one to the counter.
- R4: With the prescaler off, a pin that stays high for at least 2 clocks and then low for at least 2 clocks is always counted. The count changes at the 3rd to 6th rising clock edge after the pin rises. A 1-clock high pulse placed wholly between two capture edges is not counted.
- R5: With `psc_en_i` set to 1, the input first drives a divider that advances on each clock in which the pin is 1 and was 0 in the previous clock. The count source is then divider bit `psc_sel_i`, which gives one count per 2^(`psc_sel_i`+1) pin edges.
- R6: When `wr_en_i` is 1, the counter loads `wr_data_i` at that edge. The same edge clears the divider and drops any pending edge. During the next 8 clocks (two instruction cycles), no increment is applied.
- R7: An increment from 0xFF gives 0x00 and sets `ovf_o`. `ovf_o` stays set until `ovf_clr_i` is 1 at a clock edge. If both happen at the same edge, setting wins.
- R8: While the reset is active, and for the first cycle after it, `count_o` is 0 and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, one phase per period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 1 | Asynchronous external event input |
| psc_en_i | input | 1 | 1 routes the input through the divider |
| psc_sel_i | input | 3 | Divider tap; ratio is 2^(value+1) |
| wr_en_i | input | 1 | Load the counter from wr_data_i |
| wr_data_i | input | 8 | Value to load |
| ovf_clr_i | input | 1 | Clear the wrap flag |
| count_o | output | 8 | Current count |
| ovf_o | output | 1 | Sticky wrap flag |

## Verification
The hardest cases to reach from the ports are the ones tied to the phase: an input edge placed at each of the four phases, and a pulse that sits in the gap between two capture edges. The bench keeps its own behavioural phase counter in step with reset. It therefore knows the current phase at every falling edge, and it can raise the pin in Q1, Q2, Q3 or Q4 on purpose, or fit a 1-clock pulse inside Q3. The write blackout is reached in the same way: the bench issues a load at a known phase and raises the pin in the very next cycle, so the pending edge lands inside the suppressed window.

// File: rtl/etm_pkg.sv
package etm_pkg;
  localparam int unsigned PHASES = 4;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;
endpackage

// File: rtl/etm_rst_sync.sv
module etm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/etm_phase_gen.sv
module etm_phase_gen
  import etm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o,
  output logic   capture_o,
  output logic   commit_o
);
  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_e'(phase_q + 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_Q1;
    else         phase_q <= phase_d;
  end

  assign phase_o   = phase_q;
  assign capture_o = (phase_q == PH_Q2) || (phase_q == PH_Q4);
  assign commit_o  = (phase_q == PH_Q4);

  AST_PHASE_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_Q4) |=> (phase_q == PH_Q1)); // R1
endmodule

// File: rtl/etm_prescaler.sv
module etm_prescaler #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned DIV_W = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tap_o
);
  logic             pin_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic             pin_rise;

  always_comb begin
    pin_rise = pin_i && !pin_q;
    if (clr_i)         div_d = '0;
    else if (pin_rise) div_d = div_q + 1'b1;
    else               div_d = div_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      div_q <= '0;
    end else begin
      pin_q <= pin_i;
      div_q <= div_d;
    end
  end

  assign tap_o = div_q[sel_i];

  AST_DIV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (div_q == '0)); // R6
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(pin_i && !pin_q)) |=> $stable(div_q)); // R5
endmodule

// File: rtl/etm_edge_sampler.sv
module etm_edge_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic capture_i,
  input  logic consume_i,
  input  logic flush_i,
  output logic pend_o
);
  logic smp_q, smp_d;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    rise  = capture_i && src_i && !smp_q;
    smp_d = capture_i ? src_i : smp_q;
    if (flush_i) pend_d = 1'b0;
    else         pend_d = (consume_i ? 1'b0 : pend_q) | rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_CAPTURE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(smp_q)); // R1
  AST_RISE_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && src_i && !smp_q && !flush_i) |=> pend_q); // R3
endmodule

// File: rtl/ext_event_timer.sv
module ext_event_timer
  import etm_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BLOCK_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_pin_i,
  input  logic             psc_en_i,
  input  logic [SEL_W-1:0] psc_sel_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int unsigned BLOCK_CLK = BLOCK_CYC * PHASES;
  localparam int unsigned BLK_W     = $clog2(BLOCK_CLK + 1);
  localparam logic [BLK_W-1:0] BLOCK_LOAD = BLK_W'(BLOCK_CLK);

  logic             rst_n;
  phase_e           phase;
  logic             capture;
  logic             commit;
  logic             tap;
  logic             src;
  logic             pend;
  logic             incr;
  logic             wrap;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic [BLK_W-1:0] blk_q, blk_d;

  etm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  etm_phase_gen u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .phase_o   (phase),
    .capture_o (capture),
    .commit_o  (commit)
  );

  etm_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .pin_i  (ext_pin_i),
    .clr_i  (wr_en_i),
    .sel_i  (psc_sel_i),
    .tap_o  (tap)
  );

  assign src = psc_en_i ? tap : ext_pin_i;

  etm_edge_sampler u_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .src_i     (src),
    .capture_i (capture),
    .consume_i (commit),
    .flush_i   (wr_en_i),
    .pend_o    (pend)
  );

  always_comb begin
    incr = commit && pend && !wr_en_i && (blk_q == '0);
    wrap = incr && (cnt_q == {CNT_W{1'b1}});

    if (wr_en_i)   cnt_d = wr_data_i;
    else if (incr) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;

    ovf_d = wrap || (ovf_q && !ovf_clr_i);

    if (wr_en_i)          blk_d = BLOCK_LOAD;
    else if (blk_q != '0) blk_d = blk_q - 1'b1;
    else                  blk_d = blk_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      blk_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      blk_q <= blk_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  AST_CHANGE_ON_Q4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!wr_en_i && phase != PH_Q4) |=> $stable(cnt_q)); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_en_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R3
  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i |=> (cnt_q == $past(wr_data_i))); // R6
  AST_BLACKOUT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (blk_q != '0 && !wr_en_i) |=> $stable(cnt_q)); // R6
  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap |=> (ovf_q && cnt_q == '0)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q); // R7
endmodule

// File: tb/ext_event_timer_bench.sv
module ext_event_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin;
  logic       psc_en;
  logic [2:0] psc_sel;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       ovf_clr;
  logic [7:0] count;
  logic       ovf;

  int total = 0;
  int bad = 0;
  string cur_req = "R8";
  bit cmp_on = 0;

  always #4 clk = ~clk;

  ext_event_timer u_ext_event_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ext_pin_i (pin),
    .psc_en_i  (psc_en),
    .psc_sel_i (psc_sel),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .ovf_clr_i (ovf_clr),
    .count_o   (count),
    .ovf_o     (ovf)
  );

  // behavioural reference model
  int m_r1, m_r2, m_ph, m_smp, m_pend, m_cnt, m_ovf, m_blk, m_div, m_pinq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_ph = 0; m_smp = 0; m_pend = 0;
      m_cnt = 0; m_ovf = 0; m_blk = 0; m_div = 0; m_pinq = 0;
    end else begin
      if (m_r2 != 0) begin
        int src, cap, rise, inc, n_pend;
        src  = psc_en ? ((m_div >> psc_sel) & 1) : int'(pin);
        cap  = (m_ph == 1 || m_ph == 3) ? 1 : 0;
        rise = (cap != 0 && src != 0 && m_smp == 0) ? 1 : 0;
        inc  = (m_ph == 3 && m_pend != 0 && !wr_en && m_blk == 0) ? 1 : 0;
        if (inc != 0 && m_cnt == 255) m_ovf = 1;
        else if (ovf_clr) m_ovf = 0;
        n_pend = wr_en ? 0 : (((m_ph == 3) ? 0 : m_pend) | rise);
        if (wr_en) m_cnt = int'(wr_data);
        else if (inc != 0) m_cnt = (m_cnt + 1) % 256;
        if (wr_en) m_blk = 8;
        else if (m_blk > 0) m_blk = m_blk - 1;
        if (wr_en) m_div = 0;
        else if (pin && m_pinq == 0) m_div = (m_div + 1) % 256;
        m_pinq = int'(pin);
        if (cap != 0) m_smp = src;
        m_pend = n_pend;
        m_ph = (m_ph + 1) % 4;
      end
      m_r2 = m_r1;
      m_r1 = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk({cur_req, " count"}, int'(count), m_cnt);
      chk({cur_req, " ovf"}, int'(ovf), m_ovf);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; cyc(hi);
      pin = 1'b0; cyc(lo);
    end
  endtask

  task automatic load(input int v);
    wr_data = 8'(v); wr_en = 1'b1; cyc(1);
    wr_en = 1'b0; cyc(12);
  endtask

  task automatic wait_phase(input int p);
    while (m_ph != p) cyc(1);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("  test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    rst_n = 1'b0; pin = 1'b0; psc_en = 1'b0; psc_sel = 3'd0;
    wr_en = 1'b0; wr_data = 8'd0; ovf_clr = 1'b0;
    cyc(3);
    chk("R8 reset count", int'(count), 0);
    chk("R8 reset ovf", int'(ovf), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R8 first cycle count", int'(count), 0);
    cmp_on = 1;
    cyc(4);

    // R3: slow pulses, one count each
    cur_req = "R3";
    pulses(10, 4, 4);
    cyc(8);
    chk("R3 ten slow pulses", int'(count), 10);

    // R4: minimum legal pulse width
    cur_req = "R4";
    load(0);
    pulses(12, 2, 2);
    cyc(8);
    chk("R4 twelve 2/2 pulses", int'(count), 12);

    // R4 / R1 / R2: latency from each phase
    for (int p = 0; p < 4; p++) begin
      int n, c0;
      wait_phase(p);
      c0 = int'(count);
      pin = 1'b1;
      n = 0;
      while (int'(count) == c0 && n < 12) begin
        @(posedge clk); #1; n++;
      end
      total++;
      if (n < 3 || n > 6) begin
        bad++;
        $display("FAIL R4 latency phase%0d actual=%0d expected=3..6", p, n);
      end
      cyc(2); pin = 1'b0; cyc(8);
    end

    // R4: 1-clock pulse inside Q3 is missed
    begin
      int c0;
      cyc(4);
      c0 = int'(count);
      wait_phase(2);
      pin = 1'b1; cyc(1); pin = 1'b0;
      cyc(10);
      chk("R4 short pulse missed", int'(count), c0);
    end

    // R5: prescaler ratios
    cur_req = "R5";
    psc_en = 1'b1;
    for (int s = 0; s < 3; s++) begin
      psc_sel = 3'(s);
      load(0);
      pulses(16, 4, 4);
      cyc(40);
      chk("R5 divided count", int'(count), 16 >> (s + 1));
    end
    psc_en = 1'b0;
    psc_sel = 3'd0;

    // R6: load and blackout
    cur_req = "R6";
    cyc(4);
    wait_phase(0);
    wr_data = 8'h40; wr_en = 1'b1; cyc(1);
    wr_en = 1'b0;
    chk("R6 loaded value", int'(count), 8'h40);
    pin = 1'b1;
    cyc(12);
    chk("R6 edge in blackout dropped", int'(count), 8'h40);
    pin = 1'b0; cyc(4);
    pulses(1, 4, 4);
    cyc(8);
    chk("R6 counting resumes", int'(count), 8'h41);

    // R7: wrap and sticky flag
    cur_req = "R7";
    load(8'hFE);
    pulses(3, 4, 4);
    cyc(8);
    chk("R7 wrapped count", int'(count), 1);
    chk("R7 flag set", int'(ovf), 1);
    pulses(1, 4, 4);
    cyc(8);
    chk("R7 flag sticky", int'(ovf), 1);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    chk("R7 flag cleared", int'(ovf), 0);
    cyc(4);

    done = 1;
    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule